// File: doc/BRIEF.md
# Wave-Addressed Shared Packet Buffer

This block is the central store of a small packet switch. All input ports write into one common pool of packet slots, and all output ports read from it. No port has storage set aside for it. A packet has a fixed length of `NWORD` words. The storage is made of `NWORD` independent banks, so word k of every packet lives in bank k. Each slot uses one common address in all of the banks.

A transfer starts in bank 0. Its slot address and direction then travel one bank per clock, so each packet moves as a diagonal wave through the banks. Each cycle, at most one write wave and at most one read wave may start. Round-robin arbiters choose among the competing ports. Free slots come from a free list that is full after reset. When a write starts, its slot goes into the FIFO of its chosen output. When the read wave of a slot leaves the last bank, the slot goes back to the free list.

A read may start on a slot as early as the cycle after the slot's write started. A packet can therefore leave through an idle output while it is still arriving (cut-through). The read wave runs one or more banks behind the write wave.

Top module: `shbuf_wave_top`

## Requirements
- R1: After reset the free list holds all `NSLOT` slots. With no reads, exactly `NSLOT` write starts are granted before further writes are refused. No grant and no `rd_valid` is active right after reset.
- R2: At most one bit of `wr_gnt` is set per cycle. `wr_gnt` responds in the same cycle to the eligible `wr_req` bits. Eligible means the port is requesting, is not busy, and a free slot exists. The grant goes to the first eligible port at or after the port following the last write grantee, in increasing index order with wrap (the pointer is 0 after reset).
- R3: A port granted in cycle t supplies word k of its packet on its `wr_data` slice in cycle t+k, for k = 0 .. NWORD-1. The destination output is taken from its `wr_dest` slice in cycle t.
- R4: While no free slot exists, `wr_gnt` stays zero for any `wr_req` pattern.
- R5: At most one bit of `rd_gnt` is set per cycle. An output is eligible when `rd_rdy` is high, its queue holds a slot whose write started in an earlier cycle, and it is not busy. Among eligible outputs the same round-robin rule as R2 applies, with its own pointer.
- R6: An output granted in cycle t shows word k of the packet on its `rd_data` slice with `rd_valid` high in cycle t+k+1. `rd_last` is high only with word NWORD-1. `rd_valid` is low in every other cycle.
- R7: Each output delivers its packets in the order their write waves started, with contents equal to the words written.
- R8: A read may be granted in the cycle right after the write grant of the same slot. The packet then passes through intact while it is still being written.
- R9: A port granted in cycle t is not granted again in the same direction before cycle t+NWORD. A grant exactly in cycle t+NWORD is allowed.
- R10: A slot returns to the free list at the end of the cycle in which its read wave reads the last bank. Once all packets have drained, `NSLOT` writes are again accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | NPORT | Per input port: a packet is ready to be written |
| wr_dest | input | NPORT*clog2(NPORT) | Per input port: destination output index |
| wr_data | input | NPORT*WORD_W | Per input port: current packet word |
| wr_gnt | output | NPORT | One-hot write start grant (combinational) |
| rd_rdy | input | NPORT | Per output port: ready to accept a new packet |
| rd_gnt | output | NPORT | One-hot read start grant (combinational) |
| rd_valid | output | NPORT | Per output port: `rd_data` slice holds a packet word |
| rd_last | output | NPORT | Per output port: the current word is the final one |
| rd_data | output | NPORT*WORD_W | Per output port: packet word |

## Verification
A stage register that steers a wave to the wrong port or slot shows up at the ports within `NWORD` cycles. It appears as a misplaced `rd_valid` or as a wrong word, compared every cycle against a behavioural model of queues and free-slot counts. A free list or output queue that loses or duplicates a slot may stay hidden for longer. It becomes visible at the next fill after a full drain, when the grant count differs from `NSLOT`, or as a grant vector that disagrees with the model in the cycle the pool runs out. An arbiter pointer error shows in the first contested cycle, because every grant vector is compared.

// File: rtl/shbuf_pkg.sv
package shbuf_pkg;

    localparam int unsigned DEF_PORTS = 8;
    localparam int unsigned DEF_WORD_W = 16;
    localparam int unsigned DEF_NWORD = 8;
    localparam int unsigned DEF_NSLOT = 64;

    // Increment with wrap at n.
    function automatic int wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/shbuf_rr_arb.sv
module shbuf_rr_arb
    import shbuf_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [IW-1:0] ptr;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            int c;
            c = int'(ptr) + i;
            if (c >= N) c = c - N;
            if (!any && req[c]) begin
                any = 1'b1;
                idx = IW'(c);
            end
        end
        gnt = any ? (N'(1) << idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (any) ptr <= IW'(wrap_inc(int'(idx), N));
    end
endmodule

// File: rtl/shbuf_addr_fifo.sv
module shbuf_addr_fifo
    import shbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW = 6,
    parameter bit INIT_FULL = 1'b0,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;

    assign dout  = mem[rp];
    assign empty = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= INIT_FULL ? CW'(DEPTH) : '0;
            if (INIT_FULL)
                for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i);
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp <= AW'(wrap_inc(int'(wp), DEPTH));
            end
            if (pop) rp <= AW'(wrap_inc(int'(rp), DEPTH));
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // A slot must never be pushed into a full list (R10: returns only what was taken)
    assert_fifo_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (cnt < CW'(DEPTH)));
    // Nothing is taken from an empty list (R4)
    assert_fifo_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0));
endmodule

// File: rtl/shbuf_bank.sv
module shbuf_bank #(
    parameter int DEPTH = 64,
    parameter int W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/shbuf_wave_top.sv
module shbuf_wave_top
    import shbuf_pkg::*;
#(
    parameter int NPORT = DEF_PORTS,
    parameter int WORD_W = DEF_WORD_W,
    parameter int NWORD = DEF_NWORD,
    parameter int NSLOT = DEF_NSLOT,
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int SW = $clog2(NSLOT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        wr_req,
    input  logic [NPORT*PW-1:0]     wr_dest,
    input  logic [NPORT*WORD_W-1:0] wr_data,
    output logic [NPORT-1:0]        wr_gnt,
    input  logic [NPORT-1:0]        rd_rdy,
    output logic [NPORT-1:0]        rd_gnt,
    output logic [NPORT-1:0]        rd_valid,
    output logic [NPORT-1:0]        rd_last,
    output logic [NPORT*WORD_W-1:0] rd_data
);
    typedef struct packed {
        logic          vld;
        logic [PW-1:0] port;
        logic [SW-1:0] slot;
    } wave_t;

    wave_t wst0, rst0;
    wave_t wpipe [NWORD-1:1];
    wave_t rpipe [NWORD-1:1];

    logic [NPORT-1:0] wbusy, rbusy, wreq_ok, rreq_ok, qempty;
    logic [PW-1:0]    widx, ridx;
    logic             wany, rany, fl_empty;
    logic [SW-1:0]    fl_head;
    logic [SW-1:0]    qhead [NPORT];
    logic [PW-1:0]    wdest;

    logic [WORD_W-1:0] bdata [NWORD];
    logic              bvld  [NWORD];
    logic [PW-1:0]     bport [NWORD];

    // Ports still running a wave may not start another
    always_comb begin
        wbusy = '0;
        rbusy = '0;
        for (int k = 1; k < NWORD; k++) begin
            if (wpipe[k].vld) wbusy[wpipe[k].port] = 1'b1;
            if (rpipe[k].vld) rbusy[rpipe[k].port] = 1'b1;
        end
    end

    assign wreq_ok = wr_req & ~wbusy & {NPORT{!fl_empty}};
    assign rreq_ok = rd_rdy & ~qempty & ~rbusy;

    shbuf_rr_arb #(.N(NPORT)) u_warb (
        .clk(clk), .rst(rst), .req(wreq_ok), .gnt(wr_gnt), .idx(widx), .any(wany));
    shbuf_rr_arb #(.N(NPORT)) u_rarb (
        .clk(clk), .rst(rst), .req(rreq_ok), .gnt(rd_gnt), .idx(ridx), .any(rany));

    assign wdest = wr_dest[widx*PW +: PW];
    assign wst0  = '{vld: wany, port: widx, slot: fl_head};
    assign rst0  = '{vld: rany, port: ridx, slot: qhead[ridx]};

    shbuf_addr_fifo #(.DEPTH(NSLOT), .DW(SW), .INIT_FULL(1'b1)) u_free (
        .clk(clk), .rst(rst),
        .push(rpipe[NWORD-1].vld), .din(rpipe[NWORD-1].slot),
        .pop(wany), .dout(fl_head), .empty(fl_empty));

    for (genvar o = 0; o < NPORT; o++) begin : g_outq
        shbuf_addr_fifo #(.DEPTH(NSLOT), .DW(SW), .INIT_FULL(1'b0)) u_q (
            .clk(clk), .rst(rst),
            .push(wany && (wdest == PW'(o))), .din(fl_head),
            .pop(rany && (ridx == PW'(o))), .dout(qhead[o]), .empty(qempty[o]));
    end

    // Address/operation pipeline: bank k sees what bank k-1 saw one cycle earlier
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k < NWORD; k++) begin
                wpipe[k] <= '0;
                rpipe[k] <= '0;
            end
        end else begin
            wpipe[1] <= wst0;
            rpipe[1] <= rst0;
            for (int k = 2; k < NWORD; k++) begin
                wpipe[k] <= wpipe[k-1];
                rpipe[k] <= rpipe[k-1];
            end
        end
    end

    for (genvar k = 0; k < NWORD; k++) begin : g_bank
        wave_t wcur, rcur;
        if (k == 0) begin : g_first
            assign wcur = wst0;
            assign rcur = rst0;
        end else begin : g_rest
            assign wcur = wpipe[k];
            assign rcur = rpipe[k];
        end

        shbuf_bank #(.DEPTH(NSLOT), .W(WORD_W)) u_bank (
            .clk(clk),
            .we(wcur.vld), .waddr(wcur.slot), .wdata(wr_data[wcur.port*WORD_W +: WORD_W]),
            .re(rcur.vld), .raddr(rcur.slot), .rdata(bdata[k]));

        always_ff @(posedge clk) begin
            if (rst) begin
                bvld[k]  <= 1'b0;
                bport[k] <= '0;
            end else begin
                bvld[k]  <= rcur.vld;
                bport[k] <= rcur.port;
            end
        end
    end

    // Steer each bank's read word to the output that owns its wave
    always_comb begin
        rd_valid = '0;
        rd_last  = '0;
        rd_data  = '0;
        for (int k = 0; k < NWORD; k++) begin
            if (bvld[k]) begin
                rd_valid[bport[k]] = 1'b1;
                rd_data[bport[k]*WORD_W +: WORD_W] = bdata[k];
                if (k == NWORD - 1) rd_last[bport[k]] = 1'b1;
            end
        end
    end

    assert_single_write_start_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_gnt));
    assert_single_read_start_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_gnt));
    assert_no_back_to_back_port_R9: assert property (@(posedge clk) disable iff (rst)
        (|wr_gnt) |=> ((wr_gnt & $past(wr_gnt)) == '0));
    assert_slot_returned_R10: assert property (@(posedge clk) disable iff (rst)
        rpipe[NWORD-1].vld |=> !fl_empty);
endmodule

// File: tb/shbuf_wave_top_test.sv
module shbuf_wave_top_test;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int NW = 8;
    localparam int NS = 64;
    localparam int PW = $clog2(N);

    typedef logic [NW*W-1:0] pkt_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]    wr_req = '0, rd_rdy = '0;
    logic [N*PW-1:0] wr_dest = '0;
    logic [N*W-1:0]  wr_data = '0;
    logic [N-1:0]    wr_gnt, rd_gnt, rd_valid, rd_last;
    logic [N*W-1:0]  rd_data;

    always #2 clk = ~clk;

    shbuf_wave_top #(.NPORT(N), .WORD_W(W), .NWORD(NW), .NSLOT(NS)) uut (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_dest(wr_dest), .wr_data(wr_data),
        .wr_gnt(wr_gnt), .rd_rdy(rd_rdy), .rd_gnt(rd_gnt), .rd_valid(rd_valid),
        .rd_last(rd_last), .rd_data(rd_data));

    // Behavioural reference model state
    pkt_t oq_pkt [N][$];
    int   oq_vis [N][$];
    pkt_t in_pkt [N], act_pkt [N], ex_pkt [N];
    int   in_dest [N], in_gs [N], ex_gs [N];
    bit   pend [N], in_act [N], ex_act [N];
    int   ret_q [$];
    int   free_cnt = NS, wptr = 0, rptr = 0, cyc = 0;
    int   checks = 0, fails = 0, gcount = 0, cut_cnt = 0;
    bit   allow_wr = 1'b0, done = 1'b0;
    int   wr_pct = 0, rdy_pct = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", rq, what, cyc, act, exp);
        end
    endtask

    task automatic step();
        int wg, rg;
        logic [N-1:0] ev_w, ev_r;
        @(negedge clk);
        cyc++;
        // Outputs: registered, compared against expected waves
        for (int o = 0; o < N; o++) begin
            bit ev;
            int k;
            ev = ex_act[o] && (cyc >= ex_gs[o] + 1) && (cyc <= ex_gs[o] + NW);
            k  = cyc - ex_gs[o] - 1;
            chk(rd_valid[o] == ev, "R6", "rd_valid", rd_valid[o], ev);
            chk(rd_last[o] == (ev && k == NW - 1), "R6", "rd_last", rd_last[o], ev && k == NW - 1);
            if (ev) begin
                chk(rd_data[o*W +: W] == ex_pkt[o][k*W +: W], "R3 R7", "rd_data",
                    rd_data[o*W +: W], ex_pkt[o][k*W +: W]);
                if (k == NW - 1) ex_act[o] = 1'b0;
            end
        end
        for (int i = ret_q.size() - 1; i >= 0; i--)
            if (ret_q[i] == cyc) begin
                free_cnt++;
                ret_q.delete(i);
            end
        // Drive inputs
        for (int p = 0; p < N; p++) begin
            if (!pend[p] && allow_wr && ($urandom_range(99) < wr_pct)) begin
                pend[p] = 1'b1;
                for (int k = 0; k < NW; k++) in_pkt[p][k*W +: W] = W'($urandom);
                in_dest[p] = $urandom_range(N - 1);
            end
            if (in_act[p] && (cyc - in_gs[p] >= NW)) in_act[p] = 1'b0;
            wr_req[p] = pend[p] && allow_wr;
            wr_dest[p*PW +: PW] = PW'(in_dest[p]);
            wr_data[p*W +: W] = in_act[p] ? act_pkt[p][(cyc - in_gs[p])*W +: W] : in_pkt[p][W-1:0];
            rd_rdy[p] = ($urandom_range(99) < rdy_pct);
        end
        #1;
        // Expected write grant
        wg = -1;
        if (free_cnt > 0)
            for (int i = 0; i < N; i++) begin
                int c;
                c = (wptr + i) % N;
                if (wg < 0 && pend[c] && allow_wr && !in_act[c]) wg = c;
            end
        ev_w = (wg < 0) ? '0 : (N'(1) << wg);
        chk(wr_gnt == ev_w, (free_cnt == 0) ? "R4" : "R2 R9", "wr_gnt", wr_gnt, ev_w);
        if (wg >= 0) begin
            wptr = (wg + 1) % N;
            in_act[wg] = 1'b1;
            in_gs[wg] = cyc;
            act_pkt[wg] = in_pkt[wg];
            pend[wg] = 1'b0;
            free_cnt--;
            gcount++;
            oq_pkt[in_dest[wg]].push_back(in_pkt[wg]);
            oq_vis[in_dest[wg]].push_back(cyc + 1);
        end
        // Expected read grant
        rg = -1;
        for (int i = 0; i < N; i++) begin
            int c;
            c = (rptr + i) % N;
            if (rg < 0 && rd_rdy[c] && oq_pkt[c].size() > 0 && oq_vis[c][0] <= cyc &&
                !(ex_act[c] && cyc <= ex_gs[c] + NW - 1)) rg = c;
        end
        ev_r = (rg < 0) ? '0 : (N'(1) << rg);
        chk(rd_gnt == ev_r, "R5 R9", "rd_gnt", rd_gnt, ev_r);
        if (rg >= 0) begin
            rptr = (rg + 1) % N;
            if (oq_vis[rg][0] == cyc) cut_cnt++;
            ex_pkt[rg] = oq_pkt[rg].pop_front();
            void'(oq_vis[rg].pop_front());
            ex_act[rg] = 1'b1;
            ex_gs[rg] = cyc;
            ret_q.push_back(cyc + NW);
        end
    endtask

    task automatic run(input int n, input bit aw, input int wp, input int rp);
        allow_wr = aw;
        wr_pct = wp;
        rdy_pct = rp;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(wr_gnt == '0 && rd_gnt == '0, "R1", "grants after reset", {wr_gnt, rd_gnt}, 0);
        chk(rd_valid == '0, "R1", "rd_valid after reset", rd_valid, 0);

        gcount = 0;
        run(300, 1'b1, 100, 0);
        chk(gcount == NS, "R1", "slots accepted from reset", gcount, NS);
        run(1000, 1'b0, 0, 100);

        run(3000, 1'b1, 40, 60);
        run(1000, 1'b0, 0, 100);

        gcount = 0;
        run(300, 1'b1, 100, 0);
        chk(gcount == NS, "R10", "slots accepted after drain", gcount, NS);
        run(1000, 1'b0, 0, 100);

        cut_cnt = 0;
        run(600, 1'b1, 5, 100);
        chk(cut_cnt > 0, "R8", "cut-through reads seen", cut_cnt, 1);
        run(1000, 1'b0, 0, 100);

        for (int o = 0; o < N; o++)
            chk(oq_pkt[o].size() == 0 && !ex_act[o], "R7", "output drained",
                oq_pkt[o].size(), 0);
        chk(free_cnt == NS, "R10", "free slots at end", free_cnt, NS);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end
endmodule